// File: doc/BRIEF.md
# One-Time-Programmable Array Program-and-Verify Sequencer

This block burns a range of bytes into a one-time-programmable memory array, one address at a time. A start command sets a lowest and a highest address. For each address the sequencer asks a data source for the byte, then drives the array's chip-enable and program strobes. The program strobe is held low for a fixed number of clock cycles, chosen so that the pulse lasts 0.1 ms (a window of 0.095 to 0.105 ms is acceptable). After the pulse, the sequencer reads the cell back and compares it with the intended byte. On a mismatch it applies another pulse, up to a limit of attempts for that address. When the byte matches, it moves on to the next address.

When the highest address has been programmed, the high-voltage mode flag drops. The sequencer then reads the whole range once more and compares every byte against the data source again. It ends with a one-cycle done pulse that carries a pass or an error indication. On an error, the offending address is reported. A counter of all pulses applied in the run stays visible until the next start. The supply rails are not switched here: the mode flag tells the surrounding logic which rail level is wanted.

The array is fully erased to all ones and can only clear bits. A full array is burned with an address width of 17 over the range 0x00000 to 0x1FFFF. Locking read-out is done with the one-address range 0x00000 to 0x00000 and the byte 0xFE, which clears bit 0 of address 0.

Top module: `otp_burn_seq`

## Requirements
- R1: A start command seen while idle with lowest address <= highest address makes `busy_o` high and `hv_mode_o` high for the whole programming phase; the program strobe is never low while `hv_mode_o` is low.
- R2: Every program pulse holds `arr_pgm_n_o` low for exactly PULSE_CYC consecutive cycles. During the pulse `arr_ce_n_o` is low, `arr_oe_n_o` is high, and `arr_addr_o` and `arr_wdata_o` do not change.
- R3: After each pulse the cell is read with `arr_ce_n_o` and `arr_oe_n_o` low for RD_WAIT cycles. `arr_rdata_i` is compared with the byte the source supplied, in the last of those cycles.
- R4: On a read-back mismatch another pulse is applied, up to MAX_TRIES pulses per address. A mismatch after the MAX_TRIES-th pulse ends the run with done and error, with `fail_addr_o` holding that address; no further pulse follows. The attempt count starts from zero at every new address.
- R5: On a match the address advances by one. The programming phase ends after the highest address; no address outside the range is ever pulsed.
- R6: The final pass runs with `hv_mode_o` low and reads each address from lowest to highest exactly once against freshly fetched source data. The first mismatch ends the run with error and `fail_addr_o` set to that address. If all addresses match, the run ends with pass.
- R7: `pulse_cnt_o` is cleared by an accepted start and rises by one at the end of each pulse. It holds its value after done until the next accepted start.
- R8: `done_o` is high for one cycle, together with exactly one of `pass_o` or `error_o`; `busy_o` is low in the following cycle.
- R9: A start command while `busy_o` is high has no effect on the run in progress.
- R10: A start with highest address below lowest address raises done with error in the cycle right after the start is taken. `fail_addr_o` then equals the lowest address, and no pulse is applied.
- R11: For each address in either phase, `src_req_o` stays high with `src_addr_o` equal to that address until `src_ack_i`. `src_data_i` is taken in the acknowledge cycle.
- R12: After reset the block is idle: strobes `arr_ce_n_o`, `arr_oe_n_o`, `arr_pgm_n_o` high, `hv_mode_o`, `busy_o`, `done_o`, `pass_o`, `error_o` low, `pulse_cnt_o` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command, taken only when idle |
| range_lo_i | input | ADDR_W | Lowest address of the run |
| range_hi_i | input | ADDR_W | Highest address of the run |
| src_req_o | output | 1 | Data request to the byte source |
| src_addr_o | output | ADDR_W | Address whose byte is requested |
| src_ack_i | input | 1 | Source acknowledge, data valid |
| src_data_i | input | DATA_W | Byte for the requested address |
| arr_addr_o | output | ADDR_W | Array address |
| arr_wdata_o | output | DATA_W | Array program data |
| arr_ce_n_o | output | 1 | Array chip enable, active low |
| arr_oe_n_o | output | 1 | Array output enable, active low |
| arr_pgm_n_o | output | 1 | Array program strobe, active low |
| arr_rdata_i | input | DATA_W | Array read data |
| hv_mode_o | output | 1 | High-voltage rail requested (programming phase) |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Run passed, with done |
| error_o | output | 1 | Run failed, with done |
| fail_addr_o | output | ADDR_W | Address at which the last failed run stopped |
| pulse_cnt_o | output | PCNT_W | Pulses applied since the last accepted start |

## Verification
The bench builds the block with a 6-bit address, a 5-cycle pulse, a 2-cycle read wait and the full limit of 25 attempts. With these values every address from 0 to 63 fits in a small bench array model, so the top edge of the address space is reachable. A cell that needs exactly 25 pulses, and one that needs 26, can be tried within a few hundred cycles each. The array model clears bits only after a per-address number of pulses, and it can corrupt one byte in the final read. This lets the attempt limit, the error address, the pulse total and the separate verify failure be computed from the stimulus alone.

// File: rtl/otp_seq_pkg.sv
`timescale 1ns/1ps
package otp_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FETCH  = 3'd1,
    ST_PULSE  = 3'd2,
    ST_READ   = 3'd3,
    ST_VFETCH = 3'd4,
    ST_VREAD  = 3'd5,
    ST_FINISH = 3'd6
  } seq_state_e;

endpackage

// File: rtl/otp_cycle_timer.sv
`timescale 1ns/1ps
module otp_cycle_timer #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/otp_addr_walker.sv
`timescale 1ns/1ps
module otp_addr_walker #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              rewind_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);

  logic [ADDR_W-1:0] lo_q, lo_d;
  logic [ADDR_W-1:0] hi_q, hi_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    lo_d   = lo_q;
    hi_d   = hi_q;
    addr_d = addr_q;
    if (init_i) begin
      lo_d   = lo_i;
      hi_d   = hi_i;
      addr_d = lo_i;
    end else if (rewind_i) begin
      addr_d = lo_q;
    end else if (step_i) begin
      addr_d = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      addr_q <= '0;
    end else begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      addr_q <= addr_d;
    end
  end

  assign addr_o = addr_q;
  assign last_o = (addr_q == hi_q);

endmodule

// File: rtl/otp_attempt_ctr.sv
`timescale 1ns/1ps
module otp_attempt_ctr #(
  parameter int TRY_W  = 5,
  parameter int PCNT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_clr_i,
  input  logic              try_clr_i,
  input  logic              pulse_i,
  output logic [TRY_W-1:0]  tries_o,
  output logic [PCNT_W-1:0] total_o
);

  logic [TRY_W-1:0]  tries_q, tries_d;
  logic [PCNT_W-1:0] total_q, total_d;

  always_comb begin
    tries_d = tries_q;
    total_d = total_q;
    if (run_clr_i) begin
      total_d = '0;
    end
    if (try_clr_i) begin
      tries_d = '0;
    end
    if (pulse_i) begin
      tries_d = tries_q + 1'b1;
      total_d = total_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tries_q <= '0;
      total_q <= '0;
    end else begin
      tries_q <= tries_d;
      total_q <= total_d;
    end
  end

  assign tries_o = tries_q;
  assign total_o = total_q;

endmodule

// File: rtl/otp_burn_seq.sv
`timescale 1ns/1ps
module otp_burn_seq
  import otp_seq_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int PULSE_CYC = 12500,
  parameter int RD_WAIT   = 4,
  parameter int MAX_TRIES = 25,
  parameter int PCNT_W    = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] range_lo_i,
  input  logic [ADDR_W-1:0] range_hi_i,
  output logic              src_req_o,
  output logic [ADDR_W-1:0] src_addr_o,
  input  logic              src_ack_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_wdata_o,
  output logic              arr_ce_n_o,
  output logic              arr_oe_n_o,
  output logic              arr_pgm_n_o,
  input  logic [DATA_W-1:0] arr_rdata_i,
  output logic              hv_mode_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              error_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [PCNT_W-1:0] pulse_cnt_o
);

  localparam int TMR_MAX = (PULSE_CYC > RD_WAIT) ? PULSE_CYC : RD_WAIT;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int TRY_W   = $clog2(MAX_TRIES + 1);
  localparam logic [TMR_W-1:0] PULSE_LD = TMR_W'(PULSE_CYC - 1);
  localparam logic [TMR_W-1:0] READ_LD  = TMR_W'(RD_WAIT - 1);
  localparam logic [TRY_W-1:0] TRY_LIM  = TRY_W'(MAX_TRIES);

  seq_state_e state_q, state_d;

  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_exp;
  logic              walk_init, walk_rewind, walk_step;
  logic [ADDR_W-1:0] walk_addr;
  logic              walk_last;
  logic              run_clr, try_clr, pulse_inc;
  logic [TRY_W-1:0]  tries;
  logic              cap_data;
  logic              set_pass, set_err;
  logic              range_bad;
  logic              byte_ok;

  logic [DATA_W-1:0] data_q;
  logic              ok_q;
  logic [ADDR_W-1:0] fail_q;
  logic [ADDR_W-1:0] fail_d;

  otp_cycle_timer #(.CNT_W(TMR_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_exp)
  );

  otp_addr_walker #(.ADDR_W(ADDR_W)) u_walker (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_i   (walk_init),
    .rewind_i (walk_rewind),
    .step_i   (walk_step),
    .lo_i     (range_lo_i),
    .hi_i     (range_hi_i),
    .addr_o   (walk_addr),
    .last_o   (walk_last)
  );

  otp_attempt_ctr #(.TRY_W(TRY_W), .PCNT_W(PCNT_W)) u_tries (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_clr_i (run_clr),
    .try_clr_i (try_clr),
    .pulse_i   (pulse_inc),
    .tries_o   (tries),
    .total_o   (pulse_cnt_o)
  );

  assign range_bad = (range_hi_i < range_lo_i);
  assign byte_ok   = (arr_rdata_i == data_q);

  // next-state and control decode
  always_comb begin
    state_d     = state_q;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    walk_init   = 1'b0;
    walk_rewind = 1'b0;
    walk_step   = 1'b0;
    run_clr     = 1'b0;
    try_clr     = 1'b0;
    pulse_inc   = 1'b0;
    cap_data    = 1'b0;
    set_pass    = 1'b0;
    set_err     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          run_clr = 1'b1;
          if (range_bad) begin
            set_err = 1'b1;
            state_d = ST_FINISH;
          end else begin
            walk_init = 1'b1;
            try_clr   = 1'b1;
            state_d   = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        if (src_ack_i) begin
          cap_data = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = PULSE_LD;
          state_d  = ST_PULSE;
        end
      end
      ST_PULSE: begin
        if (tmr_exp) begin
          pulse_inc = 1'b1;
          tmr_load  = 1'b1;
          tmr_val   = READ_LD;
          state_d   = ST_READ;
        end
      end
      ST_READ: begin
        if (tmr_exp) begin
          if (byte_ok) begin
            if (walk_last) begin
              walk_rewind = 1'b1;
              state_d     = ST_VFETCH;
            end else begin
              walk_step = 1'b1;
              try_clr   = 1'b1;
              state_d   = ST_FETCH;
            end
          end else if (tries >= TRY_LIM) begin
            set_err = 1'b1;
            state_d = ST_FINISH;
          end else begin
            tmr_load = 1'b1;
            tmr_val  = PULSE_LD;
            state_d  = ST_PULSE;
          end
        end
      end
      ST_VFETCH: begin
        if (src_ack_i) begin
          cap_data = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = READ_LD;
          state_d  = ST_VREAD;
        end
      end
      ST_VREAD: begin
        if (tmr_exp) begin
          if (!byte_ok) begin
            set_err = 1'b1;
            state_d = ST_FINISH;
          end else if (walk_last) begin
            set_pass = 1'b1;
            state_d  = ST_FINISH;
          end else begin
            walk_step = 1'b1;
            state_d   = ST_VFETCH;
          end
        end
      end
      ST_FINISH: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  assign fail_d = (state_q == ST_IDLE) ? range_lo_i : walk_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (cap_data) begin
      data_q <= src_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q   <= 1'b0;
      fail_q <= '0;
    end else if (set_err) begin
      ok_q   <= 1'b0;
      fail_q <= fail_d;
    end else if (set_pass) begin
      ok_q   <= 1'b1;
    end
  end

  // outputs decoded from the state register
  assign busy_o      = (state_q != ST_IDLE);
  assign hv_mode_o   = (state_q == ST_FETCH) || (state_q == ST_PULSE) || (state_q == ST_READ);
  assign arr_pgm_n_o = !(state_q == ST_PULSE);
  assign arr_oe_n_o  = !((state_q == ST_READ) || (state_q == ST_VREAD));
  assign arr_ce_n_o  = !((state_q == ST_PULSE) || (state_q == ST_READ) || (state_q == ST_VREAD));
  assign src_req_o   = (state_q == ST_FETCH) || (state_q == ST_VFETCH);
  assign src_addr_o  = walk_addr;
  assign arr_addr_o  = walk_addr;
  assign arr_wdata_o = data_q;
  assign done_o      = (state_q == ST_FINISH);
  assign pass_o      = done_o && ok_q;
  assign error_o     = done_o && !ok_q;
  assign fail_addr_o = fail_q;

endmodule

// File: rtl/otp_burn_seq_chk.sv
`timescale 1ns/1ps
module otp_burn_seq_chk #(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int MAX_TRIES = 25,
  parameter int PCNT_W    = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              ce_n,
  input logic              oe_n,
  input logic              pgm_n,
  input logic              hv,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              error,
  input logic [PCNT_W-1:0] pulse_cnt
);

  localparam int TC_W = $clog2(MAX_TRIES + 2) + 1;

  logic [TC_W-1:0]   try_cnt_q;
  logic [ADDR_W-1:0] addr_seen_q;
  logic              pgm_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      try_cnt_q   <= '0;
      addr_seen_q <= '0;
      pgm_seen_q  <= 1'b1;
    end else begin
      addr_seen_q <= addr;
      pgm_seen_q  <= pgm_n;
      if (!busy || (addr != addr_seen_q)) begin
        try_cnt_q <= '0;
      end else if (!pgm_n && pgm_seen_q && (try_cnt_q != '1)) begin
        try_cnt_q <= try_cnt_q + 1'b1;
      end
    end
  end

  // R1
  pgm_needs_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pgm_n |-> hv);

  // R2
  pgm_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pgm_n |-> (!ce_n && oe_n));

  // R2
  pgm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pgm_n && !$past(pgm_n)) |-> ($stable(addr) && $stable(wdata)));

  // R4
  try_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    try_cnt_q <= TC_W'(MAX_TRIES));

  // R7
  pulse_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgm_n) |-> (pulse_cnt == PCNT_W'($past(pulse_cnt) + 1'b1)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass ^ error));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

bind otp_burn_seq otp_burn_seq_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .MAX_TRIES (MAX_TRIES),
  .PCNT_W    (PCNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (arr_addr_o),
  .wdata     (arr_wdata_o),
  .ce_n      (arr_ce_n_o),
  .oe_n      (arr_oe_n_o),
  .pgm_n     (arr_pgm_n_o),
  .hv        (hv_mode_o),
  .busy      (busy_o),
  .done      (done_o),
  .pass      (pass_o),
  .error     (error_o),
  .pulse_cnt (pulse_cnt_o)
);

// File: tb/tb_otp_burn_seq.sv
`timescale 1ns/1ps
module tb_otp_burn_seq;

  localparam int AW = 6;
  localparam int DW = 8;
  localparam int PC = 5;
  localparam int RW = 2;
  localparam int MT = 25;
  localparam int PW = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [AW-1:0] range_lo, range_hi;
  logic          src_req, src_ack;
  logic [AW-1:0] src_addr;
  logic [DW-1:0] src_data;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata, arr_rdata;
  logic          arr_ce_n, arr_oe_n, arr_pgm_n;
  logic          hv, busy, done, pass, error;
  logic [AW-1:0] fail_addr;
  logic [PW-1:0] pulse_cnt;

  otp_burn_seq #(
    .ADDR_W(AW), .DATA_W(DW), .PULSE_CYC(PC), .RD_WAIT(RW),
    .MAX_TRIES(MT), .PCNT_W(PW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .range_lo_i(range_lo), .range_hi_i(range_hi),
    .src_req_o(src_req), .src_addr_o(src_addr), .src_ack_i(src_ack), .src_data_i(src_data),
    .arr_addr_o(arr_addr), .arr_wdata_o(arr_wdata), .arr_ce_n_o(arr_ce_n),
    .arr_oe_n_o(arr_oe_n), .arr_pgm_n_o(arr_pgm_n), .arr_rdata_i(arr_rdata),
    .hv_mode_o(hv), .busy_o(busy), .done_o(done), .pass_o(pass), .error_o(error),
    .fail_addr_o(fail_addr), .pulse_cnt_o(pulse_cnt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk;
  int n_fail;

  // bench model state
  logic [DW-1:0] mem [DEPTH];
  int            need [DEPTH];
  int            hits [DEPTH];
  int            ack_lat, age;
  bit            data_fe, corrupt_en;
  logic [AW-1:0] corrupt_addr;
  int            lo_cur, hi_cur;
  int            vreads, oor_hits, low_cnt;
  logic [AW-1:0] pa;
  logic [DW-1:0] pd;
  logic          oe_prev, req_prev, ack_prev;
  logic [AW-1:0] raddr_prev;

  // result of the last run
  bit r_pass, r_err;
  int r_fail, r_pulses, r_lat;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] data_of(input int a);
    if (data_fe) return 8'hFE;
    return DW'((a * 37 + 11) ^ 8'h5A);
  endfunction

  assign src_ack   = src_req && (age >= ack_lat);
  assign src_data  = data_of(int'(src_addr));
  assign arr_rdata = arr_oe_n ? 8'h00 :
                     (mem[arr_addr] ^ ((corrupt_en && !hv && arr_addr == corrupt_addr) ? 8'h10 : 8'h00));

  // array and source model, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      // R11 request held with stable address until acknowledged
      if (req_prev && !ack_prev)
        chk(src_req && src_addr == raddr_prev, "R11", "request held", int'(src_req), 1);
      if (!arr_pgm_n) begin
        if (low_cnt > 0 && (arr_addr != pa || arr_wdata != pd))
          chk(1'b0, "R2", "addr/data moved in pulse", int'(arr_addr), int'(pa));
        if (!hv) chk(1'b0, "R1", "pulse without hv", int'(hv), 1);
        if (arr_ce_n || !arr_oe_n) chk(1'b0, "R2", "ce/oe during pulse", int'(arr_ce_n), 0);
        pa = arr_addr;
        pd = arr_wdata;
        low_cnt++;
      end else if (low_cnt > 0) begin
        chk(low_cnt == PC, "R2", "pulse width", low_cnt, PC);
        hits[pa]++;
        if (int'(pa) < lo_cur || int'(pa) > hi_cur) oor_hits++;
        if (hits[pa] >= need[pa]) mem[pa] = mem[pa] & pd;
        low_cnt = 0;
      end
      if (oe_prev && !arr_oe_n && !hv) vreads++;
    end
    oe_prev    = arr_oe_n;
    req_prev   = src_req;
    raddr_prev = src_addr;
    age        = src_req ? age + 1 : 0;
    ack_prev   = src_req && (age >= ack_lat);
  end

  task automatic fresh();
    for (int i = 0; i < DEPTH; i++) begin
      mem[i]  = 8'hFF;
      need[i] = 1;
      hits[i] = 0;
    end
    corrupt_en = 1'b0;
    data_fe    = 1'b0;
    ack_lat    = 0;
    vreads     = 0;
    oor_hits   = 0;
  endtask

  task automatic kick(input int lo, input int hi);
    range_lo = AW'(lo);
    range_hi = AW'(hi);
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (!done) chk(1'b0, "R8", "watchdog expired waiting for done", n, 0);
    r_pass   = pass;
    r_err    = error;
    r_fail   = int'(fail_addr);
    r_pulses = int'(pulse_cnt);
    r_lat    = n;
    @(negedge clk);
    chk(!done, "R8", "done lasts one cycle", int'(done), 0);
    chk(!busy, "R8", "idle after done", int'(busy), 0);
  endtask

  task automatic run(input int lo, input int hi);
    lo_cur = lo;
    hi_cur = hi;
    kick(lo, hi);
    wait_done();
  endtask

  task automatic t_reset();
    chk(arr_ce_n && arr_oe_n && arr_pgm_n, "R12", "strobes idle", {arr_ce_n, arr_oe_n, arr_pgm_n}, 7);
    chk(!hv && !busy, "R12", "hv/busy low", {hv, busy}, 0);
    chk(!done && !pass && !error, "R12", "verdict low", {done, pass, error}, 0);
    chk(pulse_cnt == 0, "R12", "pulse count", pulse_cnt, 0);
  endtask

  task automatic t_basic();
    fresh();
    ack_lat = 2;
    lo_cur = 0;
    hi_cur = 7;
    kick(0, 7);
    chk(busy && hv, "R1", "busy and hv after start", {busy, hv}, 3);
    wait_done();
    chk(r_pass && !r_err, "R6", "basic run passes", r_pass, 1);
    chk(r_pulses == 8, "R7", "basic pulses", r_pulses, 8);
    chk(vreads == 8, "R6", "one verify read per address", vreads, 8);
    for (int a = 0; a < 8; a++)
      chk(mem[a] == data_of(a), "R11", "programmed byte", mem[a], data_of(a));
    repeat (3) @(negedge clk);
    chk(pulse_cnt == 8, "R7", "count held after done", pulse_cnt, 8);
  endtask

  task automatic t_retry();
    fresh();
    need[10] = 3; need[11] = 25; need[12] = 25;
    need[13] = 1; need[14] = 2;  need[15] = 7;
    run(10, 15);
    chk(r_pass, "R4", "retries within limit pass", r_pass, 1);
    chk(r_pulses == 63, "R3", "pulse total with retries", r_pulses, 63);
    chk(hits[11] == 25 && hits[12] == 25, "R4", "attempts restart per address", hits[12], 25);
  endtask

  task automatic t_stuck();
    fresh();
    need[22] = 26;
    run(20, 27);
    chk(r_err && !r_pass, "R4", "stuck cell errors", r_err, 1);
    chk(r_fail == 22, "R4", "failing address", r_fail, 22);
    chk(r_pulses == 27, "R4", "pulses up to limit", r_pulses, 27);
    chk(hits[22] == MT, "R4", "pulses on stuck cell", hits[22], MT);
    chk(hits[23] == 0 && vreads == 0, "R4", "no work after error", hits[23] + vreads, 0);
  endtask

  task automatic t_verify_fail();
    fresh();
    corrupt_en   = 1'b1;
    corrupt_addr = 6'd33;
    run(30, 35);
    chk(r_err, "R6", "verify mismatch errors", r_err, 1);
    chk(r_fail == 33, "R6", "verify failing address", r_fail, 33);
    chk(r_pulses == 6, "R6", "all addresses programmed first", r_pulses, 6);
    chk(vreads == 4, "R6", "verify stops at mismatch", vreads, 4);
  endtask

  task automatic t_security();
    fresh();
    data_fe = 1'b1;
    run(0, 0);
    chk(r_pass, "R5", "single address run passes", r_pass, 1);
    chk(mem[0] == 8'hFE, "R5", "lock byte", mem[0], 8'hFE);
    chk(r_pulses == 1 && mem[1] == 8'hFF, "R5", "one pulse only", r_pulses, 1);
  endtask

  task automatic t_empty();
    fresh();
    run(9, 4);
    chk(r_err, "R10", "reversed range errors", r_err, 1);
    chk(r_lat == 0, "R10", "done right after start", r_lat, 0);
    chk(r_fail == 9, "R10", "fail address is low bound", r_fail, 9);
    chk(r_pulses == 0 && oor_hits == 0, "R10", "no pulses", r_pulses, 0);
  endtask

  task automatic t_busy_start();
    fresh();
    lo_cur = 40;
    hi_cur = 47;
    kick(40, 47);
    repeat (15) @(negedge clk);
    range_lo = 6'd2;
    range_hi = 6'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!done, "R9", "no early done", int'(done), 0);
    wait_done();
    chk(r_pass, "R9", "run unaffected by start", r_pass, 1);
    chk(r_pulses == 8 && oor_hits == 0, "R9", "pulses unaffected", r_pulses, 8);
  endtask

  task automatic t_top();
    fresh();
    run(60, 63);
    chk(r_pass, "R5", "top of space passes", r_pass, 1);
    chk(r_pulses == 4, "R5", "top pulses", r_pulses, 4);
    chk(oor_hits == 0 && mem[0] == 8'hFF && mem[59] == 8'hFF, "R5", "no wrap or stray pulse", oor_hits, 0);
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    start = 1'b0;
    range_lo = '0;
    range_hi = '0;
    low_cnt = 0;
    age = 0;
    lo_cur = 0;
    hi_cur = 0;
    fresh();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_retry();
    t_stuck();
    t_verify_fail();
    t_security();
    t_empty();
    t_busy_start();
    t_top();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule